// File: doc/BRIEF.md
# Banked Exception Entry Unit

This block performs exception entry for a 32-bit core whose registers 29 and 30 and saved status register are banked per processor mode. Given an exception request with a type code, the current status word, the current program counter and a high-vector relocation control bit, it switches the live banked registers to the target mode's bank. It then produces the new status word, the saved status, the link value and the vector address that becomes the new program counter. Every step completes in one clock edge.

Six modes share five banks, because the user and system-user modes use the same bank. Software may also ask for a plain mode change through a separate request port, which performs the bank swap and the status mode replacement without loading a vector. The core writes the live banked registers through a small write port. Requests that name an unknown mode or exception code set a sticky error flag and change no architectural state.

Top module: `exc_entry_top`

## Requirements
- R1: After reset, the live registers r29, r30 and the saved status, all bank storage, the status and PC outputs, the error flag and both pulses are zero.
- R2: The mode field is status bits [4:0]. The encodings are user 0x10, system-user 0x1F, privileged 0x13, trap 0x17, extension 0x1B and interrupt 0x12. These map to banks as follows: user and system-user to bank 0, privileged to 1, trap to 2, extension to 3, interrupt to 4.
- R3: On a mode change whose old and new modes differ, the live r29, r30 and saved status are stored into the old mode's bank and reloaded from the new mode's bank. When the old and new modes are equal, no bank is read or written.
- R4: Exception codes are 0 (privileged call), 1 (instruction abort), 2 (data abort) and 3 (interrupt). They enter privileged mode at offset 0x08, trap mode at 0x0C, trap mode at 0x10 and interrupt mode at 0x18 respectively.
- R5: When hiVec is 1 at entry, 0xFFFF0000 is added to the vector offset.
- R6: On exception entry, the saved status becomes the incoming status word. The new status equals the incoming one with bits [4:0] set to the target mode and bit 7 (interrupt disable) set.
- R7: On exception entry, r30 takes the incoming PC, r29 takes the target bank's value (or keeps its value when the mode is unchanged), and pcOut takes the vector address with pcLoad pulsed.
- R8: A software mode change swaps banks per R3 and outputs the incoming status with only bits [4:0] replaced. It does not pulse pcLoad and leaves pcOut unchanged.
- R9: An exception with a code of 4 to 7, or any request whose old or requested mode is not one of the R2 encodings, sets errFlag (which stays set until reset). That request changes no register and does not pulse updValid.
- R10: Priority is exception over mode change over live write. The live write port (wrSel 0: r29, 1: r30, 2: saved status, 3: none) takes effect only when no request is present.
- R11: Results of an accepted exception or mode change appear after the next rising edge, with updValid high for exactly that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| excReq | input | 1 | Exception entry request |
| excCode | input | 3 | Exception type code |
| modeReq | input | 1 | Software mode change request |
| reqMode | input | 5 | Requested mode for a mode change |
| statusIn | input | 32 | Current status word |
| pcIn | input | 32 | Current program counter (r31) |
| hiVec | input | 1 | High-vector relocation control |
| wrEn | input | 1 | Live banked register write enable |
| wrSel | input | 2 | Live register select |
| wrData | input | 32 | Live register write data |
| statusOut | output | 32 | New status word |
| pcOut | output | 32 | Vector address (new r31) |
| r29Out | output | 32 | Live r29 |
| r30Out | output | 32 | Live r30 (link value) |
| bsrOut | output | 32 | Live saved status |
| updValid | output | 1 | Pulse: accepted exception or mode change |
| pcLoad | output | 1 | Pulse: exception entry loaded pcOut |
| errFlag | output | 1 | Sticky error flag |

## Verification
The bench uses the default parameters: a 32-bit data width, five banks and a high-vector base of 0xFFFF0000. With these values, every bank and every vector offset, with and without relocation, are reached by random exception and mode-change sequences. Round trips through user and system-user exercise the shared bank 0, and repeated entry into the current mode exercises the no-swap path. Random illegal modes and codes, and requests that collide with live writes, reach the error and priority paths.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int MODE_W = 5;
  localparam int CODE_W = 3;
  localparam int NUM_BANKS = 5;
  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int IDIS_BIT = 7;

  localparam logic [MODE_W-1:0] MODE_USER = 5'h10;
  localparam logic [MODE_W-1:0] MODE_SUSR = 5'h1F;
  localparam logic [MODE_W-1:0] MODE_PRIV = 5'h13;
  localparam logic [MODE_W-1:0] MODE_TRAP = 5'h17;
  localparam logic [MODE_W-1:0] MODE_EXTN = 5'h1B;
  localparam logic [MODE_W-1:0] MODE_INTR = 5'h12;

  typedef struct packed {
    logic              swap;
    logic [BANK_W-1:0] oldBank;
    logic [BANK_W-1:0] newBank;
    logic              enter;
    logic              upd;
    logic              wr;
    logic [1:0]        wrSel;
    logic              errSet;
    logic [31:0]       vec;
    logic [31:0]       nextStatus;
  } strobe_t;

  function automatic logic modeKnown(input logic [MODE_W-1:0] m);
    return m inside {MODE_USER, MODE_SUSR, MODE_PRIV, MODE_TRAP, MODE_EXTN, MODE_INTR};
  endfunction

  function automatic logic [BANK_W-1:0] modeBank(input logic [MODE_W-1:0] m);
    case (m)
      MODE_PRIV: return BANK_W'(1);
      MODE_TRAP: return BANK_W'(2);
      MODE_EXTN: return BANK_W'(3);
      MODE_INTR: return BANK_W'(4);
      default:   return BANK_W'(0);
    endcase
  endfunction
endpackage

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter logic [31:0] HI_VEC_BASE = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              excReq,
  input  logic [CODE_W-1:0] excCode,
  input  logic              modeReq,
  input  logic [MODE_W-1:0] reqMode,
  input  logic [31:0]       statusIn,
  input  logic              hiVec,
  input  logic              wrEn,
  input  logic [1:0]        wrSel,
  output strobe_t           strobes,
  output logic              errFlag
);
  logic [MODE_W-1:0] oldMode;
  logic [MODE_W-1:0] tgtMode;
  logic [7:0]        vecOff;
  logic              codeOk;

  assign oldMode = statusIn[MODE_W-1:0];

  always_comb begin
    codeOk = 1'b1;
    tgtMode = MODE_PRIV;
    vecOff = 8'h08;
    case (excCode)
      3'd0: begin tgtMode = MODE_PRIV; vecOff = 8'h08; end
      3'd1: begin tgtMode = MODE_TRAP; vecOff = 8'h0C; end
      3'd2: begin tgtMode = MODE_TRAP; vecOff = 8'h10; end
      3'd3: begin tgtMode = MODE_INTR; vecOff = 8'h18; end
      default: codeOk = 1'b0;
    endcase
  end

  always_comb begin
    strobes = '0;
    strobes.oldBank = modeBank(oldMode);
    strobes.wrSel = wrSel;
    if (excReq) begin
      if (!codeOk || !modeKnown(oldMode)) begin
        strobes.errSet = 1'b1;
      end else begin
        strobes.newBank = modeBank(tgtMode);
        strobes.swap = (tgtMode != oldMode);
        strobes.enter = 1'b1;
        strobes.upd = 1'b1;
        strobes.vec = 32'(vecOff) + (hiVec ? HI_VEC_BASE : 32'h0);
        strobes.nextStatus = statusIn;
        strobes.nextStatus[MODE_W-1:0] = tgtMode;
        strobes.nextStatus[IDIS_BIT] = 1'b1;
      end
    end else if (modeReq) begin
      if (!modeKnown(oldMode) || !modeKnown(reqMode)) begin
        strobes.errSet = 1'b1;
      end else begin
        strobes.newBank = modeBank(reqMode);
        strobes.swap = (reqMode != oldMode);
        strobes.upd = 1'b1;
        strobes.nextStatus = statusIn;
        strobes.nextStatus[MODE_W-1:0] = reqMode;
      end
    end else if (wrEn) begin
      strobes.wr = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) errFlag <= 1'b0;
    else if (strobes.errSet) errFlag <= 1'b1;
  end

  // R9: error flag is sticky
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);
  // R10: only one kind of action per cycle
  assert_one_action_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.upd, strobes.wr, strobes.errSet}));
endmodule

// File: rtl/exc_entry_dp.sv
module exc_entry_dp
  import exc_entry_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [31:0]       statusIn,
  input  logic [31:0]       pcIn,
  input  logic [DATA_W-1:0] wrData,
  output logic [31:0]       statusOut,
  output logic [31:0]       pcOut,
  output logic [DATA_W-1:0] r29Out,
  output logic [DATA_W-1:0] r30Out,
  output logic [31:0]       bsrOut,
  output logic              updValid,
  output logic              pcLoad
);
  logic [DATA_W-1:0] bank29 [NUM_BANKS];
  logic [DATA_W-1:0] bank30 [NUM_BANKS];
  logic [31:0]       bankSr [NUM_BANKS];
  logic [DATA_W-1:0] load29, load30;
  logic [31:0]       loadSr;
  logic              sameBank;

  assign sameBank = (strobes.oldBank == strobes.newBank);

  for (genvar g = 0; g < NUM_BANKS; g++) begin : gBank
    always_ff @(posedge clk) begin
      if (!rstN) begin
        bank29[g] <= '0;
        bank30[g] <= '0;
        bankSr[g] <= '0;
      end else if (strobes.swap && strobes.oldBank == BANK_W'(g)) begin
        bank29[g] <= r29Out;
        bank30[g] <= r30Out;
        bankSr[g] <= bsrOut;
      end
    end
  end

  always_comb begin
    load29 = r29Out;
    load30 = r30Out;
    loadSr = bsrOut;
    if (strobes.swap && !sameBank) begin
      load29 = bank29[strobes.newBank];
      load30 = bank30[strobes.newBank];
      loadSr = bankSr[strobes.newBank];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      r29Out <= '0;
      r30Out <= '0;
      bsrOut <= '0;
      statusOut <= '0;
      pcOut <= '0;
      updValid <= 1'b0;
      pcLoad <= 1'b0;
    end else begin
      updValid <= strobes.upd;
      pcLoad <= strobes.enter;
      if (strobes.upd) begin
        statusOut <= strobes.nextStatus;
        r29Out <= load29;
        r30Out <= strobes.enter ? DATA_W'(pcIn) : load30;
        bsrOut <= strobes.enter ? statusIn : loadSr;
      end else if (strobes.wr) begin
        case (strobes.wrSel)
          2'd0: r29Out <= wrData;
          2'd1: r30Out <= wrData;
          2'd2: bsrOut <= 32'(wrData);
          default: ;
        endcase
      end
      if (strobes.enter) pcOut <= strobes.vec;
    end
  end

  // R7: link register receives the program counter of the entry cycle
  assert_link_pc_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.enter |=> r30Out == DATA_W'($past(pcIn)));
  // R6: interrupt disable set on entry
  assert_idis_set_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.enter |=> statusOut[IDIS_BIT]);
  // R9: a rejected request changes no live register
  assert_err_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.errSet |=> !updValid && $stable(r29Out) && $stable(r30Out) && $stable(bsrOut));
  // R8: plain mode change leaves the program counter alone
  assert_pc_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.upd && !strobes.enter) |=> $stable(pcOut) && !pcLoad);
endmodule

// File: rtl/exc_entry_top.sv
module exc_entry_top
  import exc_entry_pkg::*;
#(
  parameter int          DATA_W = 32,
  parameter logic [31:0] HI_VEC_BASE = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              excReq,
  input  logic [2:0]        excCode,
  input  logic              modeReq,
  input  logic [4:0]        reqMode,
  input  logic [31:0]       statusIn,
  input  logic [31:0]       pcIn,
  input  logic              hiVec,
  input  logic              wrEn,
  input  logic [1:0]        wrSel,
  input  logic [DATA_W-1:0] wrData,
  output logic [31:0]       statusOut,
  output logic [31:0]       pcOut,
  output logic [DATA_W-1:0] r29Out,
  output logic [DATA_W-1:0] r30Out,
  output logic [31:0]       bsrOut,
  output logic              updValid,
  output logic              pcLoad,
  output logic              errFlag
);
  strobe_t strobes;

  exc_entry_ctrl #(.HI_VEC_BASE(HI_VEC_BASE)) uCtrl (
    .clk(clk), .rstN(rstN), .excReq(excReq), .excCode(excCode),
    .modeReq(modeReq), .reqMode(reqMode), .statusIn(statusIn), .hiVec(hiVec),
    .wrEn(wrEn), .wrSel(wrSel), .strobes(strobes), .errFlag(errFlag)
  );

  exc_entry_dp #(.DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .statusIn(statusIn), .pcIn(pcIn),
    .wrData(wrData), .statusOut(statusOut), .pcOut(pcOut), .r29Out(r29Out),
    .r30Out(r30Out), .bsrOut(bsrOut), .updValid(updValid), .pcLoad(pcLoad)
  );

  // R11: update pulse lasts a single cycle unless requests continue
  assert_upd_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && !$past(excReq) && !$past(modeReq)) |-> 1'b0);
endmodule

// File: tb/sim_exc_entry_top.sv
module sim_exc_entry_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic excReq = 0, modeReq = 0, hiVec = 0, wrEn = 0;
  logic [2:0] excCode = 0;
  logic [4:0] reqMode = 0;
  logic [1:0] wrSel = 0;
  logic [31:0] statusIn = 0, pcIn = 0, wrData = 0;
  logic [31:0] statusOut, pcOut, r29Out, r30Out, bsrOut;
  logic updValid, pcLoad, errFlag;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] m29, m30, mSr, mStat, mPc;
  logic [31:0] b29 [5];
  logic [31:0] b30 [5];
  logic [31:0] bSr [5];
  logic mUpd, mLoad, mErr;
  logic [4:0] curMode;

  always #2 clk = ~clk;

  exc_entry_top u0 (.*);

  function automatic bit known(input logic [4:0] m);
    return m == 5'h10 || m == 5'h1F || m == 5'h13 || m == 5'h17 || m == 5'h1B || m == 5'h12;
  endfunction

  function automatic int bankOf(input logic [4:0] m);
    case (m)
      5'h13: return 1;
      5'h17: return 2;
      5'h1B: return 3;
      5'h12: return 4;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic swapModel(input logic [4:0] oldM, input logic [4:0] newM);
    int ob, nb;
    ob = bankOf(oldM);
    nb = bankOf(newM);
    if (oldM == newM) return;
    b29[ob] = m29; b30[ob] = m30; bSr[ob] = mSr;
    m29 = b29[nb]; m30 = b30[nb]; mSr = bSr[nb];
  endtask

  // Drive one cycle, update the model, check outputs after the edge.
  task automatic step(input bit ex, input logic [2:0] code, input bit md, input logic [4:0] rm,
                      input logic [31:0] st, input logic [31:0] pc, input bit hv,
                      input bit we, input logic [1:0] ws, input logic [31:0] wd, input string tag);
    logic [4:0] om, tm;
    logic [7:0] off;
    excReq = ex; excCode = code; modeReq = md; reqMode = rm; statusIn = st;
    pcIn = pc; hiVec = hv; wrEn = we; wrSel = ws; wrData = wd;
    om = st[4:0];
    mUpd = 0; mLoad = 0;
    if (ex) begin
      if (code > 3 || !known(om)) mErr = 1;
      else begin
        case (code)
          3'd0: begin tm = 5'h13; off = 8'h08; end
          3'd1: begin tm = 5'h17; off = 8'h0C; end
          3'd2: begin tm = 5'h17; off = 8'h10; end
          default: begin tm = 5'h12; off = 8'h18; end
        endcase
        swapModel(om, tm);
        mSr = st; m30 = pc;
        mStat = {st[31:8], 1'b1, st[6:5], tm};
        mPc = 32'(off) + (hv ? 32'hFFFF0000 : 32'h0);
        mUpd = 1; mLoad = 1; curMode = tm;
      end
    end else if (md) begin
      if (!known(om) || !known(rm)) mErr = 1;
      else begin
        swapModel(om, rm);
        mStat = {st[31:5], rm};
        mUpd = 1; curMode = rm;
      end
    end else if (we) begin
      case (ws)
        2'd0: m29 = wd;
        2'd1: m30 = wd;
        2'd2: mSr = wd;
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    excReq = 0; modeReq = 0; wrEn = 0;
    chk({tag, " R2 R3 R7"}, "r29", r29Out, m29);
    chk({tag, " R3 R7 R10"}, "r30", r30Out, m30);
    chk({tag, " R3 R6 R10"}, "bsr", bsrOut, mSr);
    chk({tag, " R6 R8"}, "status", statusOut, mStat);
    chk({tag, " R4 R5"}, "pc", pcOut, mPc);
    chk({tag, " R11"}, "updValid", 32'(updValid), 32'(mUpd));
    chk({tag, " R7 R8"}, "pcLoad", 32'(pcLoad), 32'(mLoad));
    chk({tag, " R9"}, "errFlag", 32'(errFlag), 32'(mErr));
  endtask

  function automatic logic [31:0] stWord(input logic [4:0] m);
    return {$urandom(), 5'h0} | 32'(m) & 32'hFFFF_FFFF | 32'h0;
  endfunction

  initial begin
    void'($urandom(32'd1234));
    m29 = 0; m30 = 0; mSr = 0; mStat = 0; mPc = 0; mErr = 0; curMode = 5'h10;
    for (int i = 0; i < 5; i++) begin b29[i] = 0; b30[i] = 0; bSr[i] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", "r29", r29Out, 0); chk("R1", "r30", r30Out, 0); chk("R1", "bsr", bsrOut, 0);
    chk("R1", "status", statusOut, 0); chk("R1", "pc", pcOut, 0);
    chk("R1", "pulses", 32'({updValid, pcLoad, errFlag}), 0);

    // Directed: load user registers, enter each exception, high vectors
    step(0, 0, 0, 0, 32'h10, 0, 0, 1, 2'd0, 32'hAAAA0001, "dir-wr");
    step(0, 0, 0, 0, 32'h10, 0, 0, 1, 2'd1, 32'hAAAA0002, "dir-wr");
    step(1, 3'd0, 0, 0, 32'h0000_0010, 32'h1000, 0, 0, 0, 0, "R4 priv");
    step(1, 3'd1, 0, 0, {27'h0, 5'h13}, 32'h2000, 1, 0, 0, 0, "R4 R5 iabt hi");
    step(1, 3'd2, 0, 0, {27'h0, 5'h17}, 32'h3000, 0, 0, 0, 0, "R4 dabt same mode");
    step(1, 3'd3, 0, 0, {27'h0, 5'h17}, 32'h4000, 1, 0, 0, 0, "R4 R5 irq");
    step(0, 0, 1, 5'h1F, {27'h0, 5'h12}, 0, 0, 0, 0, 0, "R2 R8 to sysuser");
    step(0, 0, 1, 5'h10, {27'h0, 5'h1F}, 0, 0, 0, 0, 0, "R2 shared bank");
    step(1, 3'd5, 0, 0, {27'h0, 5'h10}, 32'h5000, 0, 0, 0, 0, "R9 bad code");
    step(0, 0, 1, 5'h04, {27'h0, 5'h10}, 0, 0, 0, 0, 0, "R9 bad mode");
    step(1, 3'd0, 1, 5'h17, {27'h0, 5'h10}, 32'h6000, 0, 1, 2'd0, 32'h1, "R10 priority");

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      int op;
      logic [4:0] m, rm;
      logic [31:0] st;
      op = $urandom_range(0, 9);
      m = ($urandom_range(0, 30) == 0) ? 5'h05 : curMode;
      st = {$urandom_range(0, 32'h7FFFFFF), m} ^ 32'h0;
      st[4:0] = m;
      case ($urandom_range(0, 6))
        0: rm = 5'h10; 1: rm = 5'h1F; 2: rm = 5'h13; 3: rm = 5'h17;
        4: rm = 5'h1B; 5: rm = 5'h12; default: rm = 5'($urandom_range(0, 31));
      endcase
      step(op < 3, 3'($urandom_range(0, 4)), op inside {[3:5]}, rm, st, $urandom(),
           1'($urandom_range(0, 1)), op >= 2, 2'($urandom_range(0, 3)), $urandom(), "rnd");
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule